// File: doc/BRIEF.md
# Down-Spread Clock Modulation Generator

This block produces a digitally synthesized clock. A phase accumulator (a numerically controlled oscillator) runs on a fast system clock. Its increment is pulled down from a nominal value along a repeating symmetric triangle. Moving the frequency continuously this way spreads the output's spectral energy and lowers its peak. The frequency is only ever swept below nominal, never above.

A 3-bit spread code selects the depth of the sweep:

- 1%, 2% or 3% below nominal, or
- no sweep at all.

The nominal increment and the spread code are sampled only at the start of each modulation period, so a sweep in progress is never cut short.

An output enable gates the clock. A separate enable flag tells the pad logic when the output should float. The current increment is brought out so that the profile can be observed.

With the defaults (200 MHz system clock, 64 steps per half-triangle, 45 cycles per step), one modulation period is 5760 cycles. That gives a sweep rate of about 34.7 kHz.

Top module: `spread_clk_gen`

## Requirements
- R1: While reset is asserted, `curInc`, `clkOut` and `clkEn` are 0. The first rising edge after reset is released samples `nomInc` and `spreadCode`. From the following cycle, `curInc` equals the sampled nominal.
- R2: Spread codes 3'b000, 3'b001, 3'b011, 3'b101 and 3'b111 select no spread. For the whole period, `curInc` stays equal to the sampled nominal.
- R3: Code 3'b010 selects a 1% depth. With depth numerator D = 41 and maxDev = (nom*D)>>12, the lowest increment in a period is nom - maxDev.
- R4: A period is 2*HALF_STEPS steps of STEP_CYCLES cycles each. In step s the level is k = s for s <= HALF_STEPS and 2*HALF_STEPS - s after that. `curInc` = nom - ((maxDev*k) >> log2(HALF_STEPS)), and it changes only at step boundaries.
- R5: `curInc` is never greater than the nominal sampled for the current period.
- R6: Changes to `spreadCode` or `nomInc` are sampled only on the edge that ends a period. Each period begins at k = 0, which is the nominal increment.
- R7: `clkEn` equals `outEn` delayed by one cycle. While `clkEn` is 0, `clkOut` is 0.
- R8: On every cycle the 24-bit phase accumulator (reset to 0) adds the `curInc` visible in that cycle. `clkOut` is the accumulator's top bit ANDed with `clkEn`.
- R9: Code 3'b100 uses D = 82 (2%) and code 3'b110 uses D = 123 (3%), with the same bottom rule as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock driving the accumulator |
| rstN | input | 1 | Asynchronous active-low reset |
| spreadCode | input | 3 | Depth select, sampled at period start |
| nomInc | input | PHASE_W | Nominal phase increment, sampled at period start |
| outEn | input | 1 | Output enable |
| clkOut | output | 1 | Modulated clock, low when disabled |
| clkEn | output | 1 | Output driver enable, low means float |
| curInc | output | PHASE_W | Increment applied in the current cycle |

## Verification
The bound checker examines several properties on every cycle:

- the increment never rises above the latched nominal;
- the increment holds between profile strobes;
- the latched depth and nominal change only on a period strobe;
- a no-spread setting keeps the increment flat;
- the enable flag follows the enable input;
- the clock is quiet while disabled.

Some behaviour can only be shown by the bench's scenarios, because it needs a cycle-exact reference of the triangle arithmetic and the accumulated phase. This covers the exact step values, the bottom levels for each depth, the period length, mid-period code changes that are deferred, and the phase and clock waveform.

// File: rtl/spread_pkg.sv
`timescale 1ns/1ps
package spread_pkg;

  typedef struct packed {
    logic load;     // sample nominal and depth, clear deviation
    logic devUp;    // deviation grows by one step
    logic devDown;  // deviation shrinks by one step
  } modStrobe_t;

  localparam int DEV_FRAC_W  = 12;
  localparam int DEPTH_NUM_W = 7;

  // depth numerator over 2^DEV_FRAC_W; zero means no spread
  function automatic logic [DEPTH_NUM_W-1:0] depthNum(input logic [2:0] code);
    case (code)
      3'b010:  depthNum = 7'd41;
      3'b100:  depthNum = 7'd82;
      3'b110:  depthNum = 7'd123;
      default: depthNum = 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/spread_ctrl.sv
`timescale 1ns/1ps
module spread_ctrl
  import spread_pkg::*;
#(
  parameter int HALF_STEPS  = 64,
  parameter int STEP_CYCLES = 45
) (
  input  logic       clk,
  input  logic       rstN,
  output modStrobe_t strb
);
  localparam int CYC_W  = $clog2(STEP_CYCLES + 1);
  localparam int STEP_W = $clog2(2 * HALF_STEPS);

  logic              loadPend;
  logic [CYC_W-1:0]  cycCnt;
  logic [STEP_W-1:0] stepIdx;
  logic [STEP_W-1:0] nextIdx;
  logic              stepEnd;
  logic              periodEnd;

  assign nextIdx   = stepIdx + STEP_W'(1);
  assign stepEnd   = (cycCnt == CYC_W'(STEP_CYCLES - 1));
  assign periodEnd = stepEnd && (stepIdx == STEP_W'(2 * HALF_STEPS - 1));

  always_comb begin
    strb.load    = loadPend || periodEnd;
    strb.devUp   = !loadPend && stepEnd && !periodEnd && (nextIdx <= STEP_W'(HALF_STEPS));
    strb.devDown = !loadPend && stepEnd && !periodEnd && (nextIdx >  STEP_W'(HALF_STEPS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPend <= 1'b1;
      cycCnt   <= '0;
      stepIdx  <= '0;
    end else if (loadPend) begin
      loadPend <= 1'b0;
    end else if (stepEnd) begin
      cycCnt  <= '0;
      stepIdx <= periodEnd ? '0 : nextIdx;
    end else begin
      cycCnt <= cycCnt + CYC_W'(1);
    end
  end

endmodule

// File: rtl/spread_dp.sv
`timescale 1ns/1ps
module spread_dp
  import spread_pkg::*;
#(
  parameter int PHASE_W    = 24,
  parameter int HALF_STEPS = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  modStrobe_t             strb,
  input  logic [2:0]             spreadCode,
  input  logic [PHASE_W-1:0]     nomInc,
  input  logic                   outEn,
  output logic                   clkOut,
  output logic                   clkEn,
  output logic [PHASE_W-1:0]     curInc,
  output logic [PHASE_W-1:0]     latchedNom,
  output logic [DEPTH_NUM_W-1:0] latchedDn
);
  localparam int SHIFT  = $clog2(HALF_STEPS);
  localparam int ACC_W  = PHASE_W + SHIFT + 1;
  localparam int PROD_W = PHASE_W + DEPTH_NUM_W;

  logic [PHASE_W-1:0]     activeNom;
  logic [DEPTH_NUM_W-1:0] activeDn;
  logic [ACC_W-1:0]       devAcc;
  logic [PHASE_W-1:0]     phase;
  logic                   oeQ;
  logic [PROD_W-1:0]      prod;
  logic [PHASE_W-1:0]     maxDev;
  logic [PHASE_W-1:0]     devOff;
  logic [PHASE_W-1:0]     incNow;

  assign prod   = PROD_W'(activeNom) * PROD_W'(activeDn);
  assign maxDev = PHASE_W'(prod >> DEV_FRAC_W);
  assign devOff = PHASE_W'(devAcc >> SHIFT);
  assign incNow = activeNom - devOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeNom <= '0;
      activeDn  <= '0;
      devAcc    <= '0;
      phase     <= '0;
      oeQ       <= 1'b0;
    end else begin
      phase <= phase + incNow;
      oeQ   <= outEn;
      if (strb.load) begin
        activeNom <= nomInc;
        activeDn  <= depthNum(spreadCode);
        devAcc    <= '0;
      end else if (strb.devUp) begin
        devAcc <= devAcc + ACC_W'(maxDev);
      end else if (strb.devDown) begin
        devAcc <= devAcc - ACC_W'(maxDev);
      end
    end
  end

  assign curInc     = incNow;
  assign clkEn      = oeQ;
  assign clkOut     = oeQ & phase[PHASE_W-1];
  assign latchedNom = activeNom;
  assign latchedDn  = activeDn;

endmodule

// File: rtl/spread_clk_gen.sv
`timescale 1ns/1ps
module spread_clk_gen
  import spread_pkg::*;
#(
  parameter int PHASE_W     = 24,
  parameter int HALF_STEPS  = 64,
  parameter int STEP_CYCLES = 45
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         spreadCode,
  input  logic [PHASE_W-1:0] nomInc,
  input  logic               outEn,
  output logic               clkOut,
  output logic               clkEn,
  output logic [PHASE_W-1:0] curInc
);
  modStrobe_t             strb;
  logic [PHASE_W-1:0]     latchedNom;
  logic [DEPTH_NUM_W-1:0] latchedDn;

  spread_ctrl #(
    .HALF_STEPS (HALF_STEPS),
    .STEP_CYCLES(STEP_CYCLES)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .strb(strb)
  );

  spread_dp #(
    .PHASE_W   (PHASE_W),
    .HALF_STEPS(HALF_STEPS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .spreadCode(spreadCode),
    .nomInc    (nomInc),
    .outEn     (outEn),
    .clkOut    (clkOut),
    .clkEn     (clkEn),
    .curInc    (curInc),
    .latchedNom(latchedNom),
    .latchedDn (latchedDn)
  );

endmodule

// File: rtl/spread_clk_gen_chk.sv
`timescale 1ns/1ps
module spread_clk_gen_chk
  import spread_pkg::*;
#(
  parameter int PHASE_W = 24
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   outEn,
  input logic                   clkOut,
  input logic                   clkEn,
  input logic [PHASE_W-1:0]     curInc,
  input logic [PHASE_W-1:0]     latchedNom,
  input logic [DEPTH_NUM_W-1:0] latchedDn,
  input modStrobe_t             strb
);

  // R5
  inc_not_above_nominal_chk: assert property (@(posedge clk) disable iff (!rstN)
    curInc <= latchedNom);

  // R2
  flat_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchedDn == '0) |-> (curInc == latchedNom));

  // R6
  settings_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(latchedDn) && $stable(latchedNom)));

  // R4
  inc_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.devUp || strb.devDown) |=> $stable(curInc));

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.devUp, strb.devDown}));

  // R7
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEn |=> clkEn);

  // R7
  enable_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |=> !clkEn);

  // R7
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> !clkOut);

endmodule

bind spread_clk_gen spread_clk_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .outEn     (outEn),
  .clkOut    (clkOut),
  .clkEn     (clkEn),
  .curInc    (curInc),
  .latchedNom(latchedNom),
  .latchedDn (latchedDn),
  .strb      (strb)
);

// File: tb/spread_clk_gen_bench.sv
`timescale 1ns/1ps
module spread_clk_gen_bench;
  localparam int PW     = 24;
  localparam int HS     = 64;
  localparam int SC     = 45;
  localparam int PERIOD = 2 * HS * SC;
  localparam int SH     = $clog2(HS);
  localparam longint MASK = (longint'(1) << PW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          outEn = 1'b0;
  logic [2:0]    code = 3'b011;
  logic [PW-1:0] nom = '0;
  wire           clkOut;
  wire           clkEn;
  wire  [PW-1:0] curInc;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spread_clk_gen u_spread_clk_gen (
    .clk(clk), .rstN(rstN), .spreadCode(code), .nomInc(nom), .outEn(outEn),
    .clkOut(clkOut), .clkEn(clkEn), .curInc(curInc)
  );

  // reference model state
  bit     mLoadPend;
  longint mT, mNom, mDn, mPhase;
  bit     mOe;

  function automatic longint dnOf(input logic [2:0] c);
    if (c == 3'b010) return 41;
    if (c == 3'b100) return 82;
    if (c == 3'b110) return 123;
    return 0;
  endfunction

  function automatic longint expInc();
    longint s, k, dev;
    s   = mT / SC;
    k   = (s <= HS) ? s : 2 * HS - s;
    dev = (mNom * mDn) >> 12;
    return mNom - ((dev * k) >> SH);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLoadPend = 1; mT = 0; mNom = 0; mDn = 0; mPhase = 0; mOe = 0;
    end else begin
      mPhase = (mPhase + expInc()) & MASK;
      mOe = outEn;
      if (mLoadPend || mT == PERIOD - 1) begin
        mLoadPend = 0; mT = 0; mNom = longint'(nom); mDn = dnOf(code);
      end else begin
        mT++;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(longint'(curInc) == expInc(), "R4 profile step", longint'(curInc), expInc());
      check(longint'(curInc) <= mNom, "R5 below nominal", longint'(curInc), mNom);
      check(clkEn == mOe, "R7 enable flag", longint'(clkEn), longint'(mOe));
      check(clkOut == (mOe && mPhase[PW-1]), "R8 phase msb", longint'(clkOut),
            longint'(mOe && mPhase[PW-1]));
      if (rstN && !mLoadPend && mT == 0)
        check(longint'(curInc) == mNom, "R6 period starts at nominal", longint'(curInc), mNom);
      if (rstN && !mLoadPend && mT == HS * SC) begin
        if (mDn == 41)
          check(longint'(curInc) == mNom - ((mNom * 41) >> 12), "R3 bottom 1pct",
                longint'(curInc), mNom - ((mNom * 41) >> 12));
        else if (mDn == 0)
          check(longint'(curInc) == mNom, "R2 no spread bottom", longint'(curInc), mNom);
        else
          check(longint'(curInc) == mNom - ((mNom * mDn) >> 12), "R9 bottom 2/3pct",
                longint'(curInc), mNom - ((mNom * mDn) >> 12));
      end
    end
  end

  task automatic run(input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i % 97 == 0) outEn = ~outEn;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    nom = 24'd3103784;
    code = 3'b011;
    repeat (3) @(negedge clk);
    check(curInc == '0, "R1 reset inc", longint'(curInc), 0);
    check(clkOut == 1'b0, "R1 reset clk", longint'(clkOut), 0);
    check(clkEn == 1'b0, "R1 reset en", longint'(clkEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(curInc == nom, "R1 first sample", longint'(curInc), longint'(nom));
    outEn = 1'b1;
    run(PERIOD / 2);
    code = 3'b010;                 // mid-period change, deferred
    run(SC * 3);
    check(curInc == nom, "R6 deferred code", longint'(curInc), longint'(nom));
    nom = 24'd2000000;             // also deferred
    run(SC * 2);
    check(curInc == 24'd3103784, "R6 deferred nominal", longint'(curInc), 3103784);
    run(PERIOD);
    code = 3'b100; run(PERIOD);
    code = 3'b110; run(PERIOD);
    code = 3'b000; run(PERIOD);
    code = 3'b001; nom = 24'd1234567; run(PERIOD);
    code = 3'b111; run(PERIOD);
    code = 3'b101; run(PERIOD);
    code = 3'b110; nom = 24'hFFFFFF; run(PERIOD);
    code = 3'b010; outEn = 1'b0; run(PERIOD + 50);
    summary();
  end

endmodule